// File: doc/BRIEF.md
# ADC Sample Gain Stage

This block scales raw converter samples by a programmable signed gain. Each sample arrives as a 16-bit offset-binary code in which the midscale code 0x8000 stands for zero. The block turns it into two's complement by flipping its top bit, then multiplies it by a signed Q1.15 coefficient to form a full-width 32-bit product.

The block narrows the product back to 16 bits by keeping product bits [30:15]. It drops the duplicated sign bit at position 31 and clamps any result that does not fit, so an oversized result never wraps.

A valid strobe travels with each sample through a two-register pipeline. Each stage is loaded only when it holds a valid sample. The output therefore keeps the last result until the next valid sample reaches it.

Top module: `adc_gain_stage`

## Requirements
- R1: An input code is converted to two's complement by inverting bit 15, so the midscale code 0x8000 counts as zero and gives an output of 0x0000 for any coefficient.
- R2: The full-scale codes 0xFFFF (+32767) and 0x0000 (-32768) convert without wrap-around. With a positive coefficient, 0xFFFF gives a non-negative output and 0x0000 gives a non-positive output.
- R3: The coefficient is a signed 16-bit Q1.15 value. The output is bits [30:15] of the 32-bit signed product, which equals floor(product / 32768).
- R4: The only product too large for the output field, -32768 × -32768 (input code 0x0000 with coefficient 0x8000), gives 0x7FFF.
- R5: `out_valid` is high exactly two rising clock edges after the edge at which `in_valid` was sampled high, and is low otherwise.
- R6: While `rst` is high at a rising edge, `out_valid` goes low and `out_data` goes to 0x0000, and any sample still in the pipeline is discarded.
- R7: When `out_valid` is low, `out_data` keeps the last value it was given.
- R8: The coefficient is sampled on the same edge as the sample it scales. A coefficient that changes between back-to-back samples applies only to the sample accepted with it.
- R9: Negative products are truncated toward minus infinity. For example, input code 0x7FFF (-1) with coefficient 0x0001 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is present on `in_sample` |
| in_sample | input | 16 | Offset-binary converter code |
| coef | input | 16 | Signed Q1.15 gain coefficient |
| out_valid | output | 1 | `out_data` carries a new result |
| out_data | output | 16 | Signed, saturated, scaled result |

## Verification
Two events can fall in the same cycle here: a clamp and a coefficient update. One case is a -1.0 × -1.0 sample that leaves the second register while the next sample enters the first register with a new coefficient. Another is a run of back-to-back samples in which the coefficient changes on every cycle. The bench provokes both, and a behavioural model built from integer arithmetic predicts the output on every clock. A result is judged correct only if the clamped value and each sample's own coefficient both appear in the right cycle.

// File: rtl/adc_gain_pkg.sv
package adc_gain_pkg;
    localparam int SAMPLE_W = 16;
    localparam int COEF_W   = 16;
    localparam int FRAC_W   = 15;
endpackage

// File: rtl/offset_to_signed.sv
module offset_to_signed #(
    parameter int W = adc_gain_pkg::SAMPLE_W
) (
    input  logic [W-1:0] raw_code,
    output logic [W-1:0] signed_code
);
    // Flipping the top bit maps midscale to zero without any carry chain.
    always_comb begin
        signed_code        = raw_code;
        signed_code[W-1]   = ~raw_code[W-1];
    end
endmodule

// File: rtl/gain_product_stage.sv
module gain_product_stage #(
    parameter int SW = adc_gain_pkg::SAMPLE_W,
    parameter int CW = adc_gain_pkg::COEF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  logic [SW-1:0]      sample_tc,
    input  logic [CW-1:0]      gain,
    output logic               prod_valid,
    output logic [SW+CW-1:0]   prod
);
    localparam int PW = SW + CW;

    logic signed [PW-1:0] sx;
    logic signed [PW-1:0] gx;
    logic signed [PW-1:0] mul;

    assign sx  = {{CW{sample_tc[SW-1]}}, sample_tc};
    assign gx  = {{SW{gain[CW-1]}}, gain};
    assign mul = sx * gx;

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_valid <= 1'b0;
            prod       <= '0;
        end else begin
            prod_valid <= take;
            if (take) begin
                prod <= mul;
            end
        end
    end
endmodule

// File: rtl/product_saturate.sv
module product_saturate #(
    parameter int SW = adc_gain_pkg::SAMPLE_W,
    parameter int CW = adc_gain_pkg::COEF_W,
    parameter int FW = adc_gain_pkg::FRAC_W
) (
    input  logic [SW+CW-1:0] prod,
    output logic [SW-1:0]    narrowed
);
    localparam int PW   = SW + CW;
    localparam int TOP  = FW + SW;
    localparam int HI_W = PW - TOP;
    localparam logic [SW-1:0] POS_MAX = {1'b0, {(SW-1){1'b1}}};
    localparam logic [SW-1:0] NEG_MIN = {1'b1, {(SW-1){1'b0}}};

    logic [SW-1:0]   field;
    logic [HI_W-1:0] high_bits;
    logic            overflow;

    assign field     = prod[TOP-1:FW];
    assign high_bits = prod[PW-1:TOP];
    assign overflow  = (high_bits != {HI_W{field[SW-1]}});

    always_comb begin
        if (overflow) begin
            narrowed = prod[PW-1] ? NEG_MIN : POS_MAX;
        end else begin
            narrowed = field;
        end
    end
endmodule

// File: rtl/adc_gain_stage.sv
module adc_gain_stage #(
    parameter int SW = adc_gain_pkg::SAMPLE_W,
    parameter int CW = adc_gain_pkg::COEF_W,
    parameter int FW = adc_gain_pkg::FRAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [SW-1:0] in_sample,
    input  logic [CW-1:0] coef,
    output logic          out_valid,
    output logic [SW-1:0] out_data
);
    localparam int PW = SW + CW;

    logic [SW-1:0] sample_tc;
    logic          s1_valid;
    logic [PW-1:0] s1_prod;
    logic [SW-1:0] s1_narrow;

    offset_to_signed #(.W(SW)) i_conv (
        .raw_code    (in_sample),
        .signed_code (sample_tc)
    );

    gain_product_stage #(.SW(SW), .CW(CW)) i_mul (
        .clk        (clk),
        .rst        (rst),
        .take       (in_valid),
        .sample_tc  (sample_tc),
        .gain       (coef),
        .prod_valid (s1_valid),
        .prod       (s1_prod)
    );

    product_saturate #(.SW(SW), .CW(CW), .FW(FW)) i_sat (
        .prod     (s1_prod),
        .narrowed (s1_narrow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_data <= s1_narrow;
            end
        end
    end
endmodule

// File: rtl/adc_gain_checker.sv
module adc_gain_checker #(
    parameter int SW = adc_gain_pkg::SAMPLE_W,
    parameter int CW = adc_gain_pkg::COEF_W
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [SW-1:0] in_sample,
    input logic [CW-1:0] coef,
    input logic          out_valid,
    input logic [SW-1:0] out_data
);
    localparam logic [SW-1:0] MID_CODE = {1'b1, {(SW-1){1'b0}}};
    localparam logic [SW-1:0] LOW_CODE = '0;
    localparam logic [CW-1:0] MINUS_ONE = {1'b1, {(CW-1){1'b0}}};
    localparam logic [SW-1:0] POS_MAX = {1'b0, {(SW-1){1'b1}}};

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R5: two-edge latency of the valid strobe
    a_r5_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R6: reset clears the output register
    a_r6_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_data == '0));

    // R7: output holds while no new result
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1 && !out_valid) |-> $stable(out_data));

    // R1: midscale input yields zero
    a_r1_midscale_zero: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && $past(in_valid, 2) && $past(in_sample, 2) == MID_CODE)
        |-> (out_data == '0));

    // R4: minus one squared clamps to the positive limit
    a_r4_clamp_pos: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && $past(in_valid, 2) && $past(in_sample, 2) == LOW_CODE
         && $past(coef, 2) == MINUS_ONE) |-> (out_data == POS_MAX));
endmodule

bind adc_gain_stage adc_gain_checker #(.SW(SW), .CW(CW)) i_adc_gain_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .coef      (coef),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/test_adc_gain_stage.sv
`timescale 1ns/1ps
module test_adc_gain_stage;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = 16'h0000;
    logic [15:0] coef = 16'h0000;
    logic        out_valid;
    logic [15:0] out_data;

    int errors = 0;
    int checks = 0;
    string cur_tag = "R3";
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // reference state
    bit          pend_v = 1'b0;
    logic [15:0] pend_d = 16'h0000;
    bit          exp_v = 1'b0;
    logic [15:0] exp_d = 16'h0000;

    always #2.5 clk = ~clk;

    adc_gain_stage i_adc_gain_stage (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .coef(coef), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [15:0] ref_gain(input logic [15:0] code, input logic [15:0] g);
        longint s;
        longint c;
        longint p;
        longint q;
        s = longint'(code) - 32768;
        c = longint'($signed(g));
        p = s * c;
        q = p >>> 15;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        return q[15:0];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            pend_v = 1'b0; pend_d = 16'h0; exp_v = 1'b0; exp_d = 16'h0;
        end else begin
            if (pend_v) exp_d = pend_d;
            exp_v = pend_v;
            pend_v = in_valid;
            if (in_valid) pend_d = ref_gain(in_sample, coef);
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !rst && !done) begin
            check("R5", {15'b0, out_valid}, {15'b0, exp_v});
            check(cur_tag, out_data, exp_d);
        end
    end

    task automatic send(input logic [15:0] code, input logic [15:0] g, input string tag);
        @(negedge clk);
        cur_tag = tag;
        in_valid = 1'b1; in_sample = code; coef = g;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R6: reset state
        check("R6", {15'b0, out_valid}, 16'h0);
        check("R6", out_data, 16'h0000);
        rst = 1'b0;
        cmp_on = 1'b1;
        idle(2);

        send(16'h8000, 16'h4000, "R1"); idle(3);
        send(16'h8000, 16'h8000, "R1"); idle(3);
        send(16'hFFFF, 16'h7FFF, "R2"); idle(3);
        send(16'h0000, 16'h7FFF, "R2"); idle(3);
        send(16'hC000, 16'h4000, "R3"); idle(3);
        send(16'h1234, 16'hA5A5, "R3"); idle(3);
        send(16'h0000, 16'h8000, "R4"); idle(3);
        send(16'hFFFF, 16'h8000, "R4"); idle(3);
        send(16'h7FFF, 16'h0001, "R9"); idle(3);
        send(16'h7000, 16'h0003, "R9"); idle(3);

        // R7: idle with coefficient and sample wandering; output must hold
        send(16'hA000, 16'h2000, "R7");
        idle(1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_sample = 16'(i * 16'h1111); coef = 16'(16'h0F0F + i);
        end

        // R8: back-to-back samples, new coefficient every cycle, clamp mixed in
        send(16'h0000, 16'h8000, "R8");
        send(16'h9000, 16'h1000, "R8");
        send(16'h9000, 16'hF000, "R8");
        send(16'hF000, 16'h7FFF, "R8");
        send(16'h0000, 16'h8000, "R8");
        send(16'h4321, 16'hC000, "R8");
        idle(4);

        // R6: mid-run reset drops in-flight samples
        send(16'hF000, 16'h7000, "R6");
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1; cur_tag = "R6";
        @(negedge clk);
        rst = 1'b0;
        check("R6", out_data, 16'h0000);
        check("R6", {15'b0, out_valid}, 16'h0);
        idle(4);

        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end
endmodule